// File: doc/BRIEF.md
# Hotswap Pass-Switch Controller

This block sequences the high-voltage pass switch that sits between a powered Ethernet input and the downstream DC-DC converter. It watches three digital flags produced by the analog front end (input undervoltage lockout released, voltage across the switch below the turn-on threshold, voltage across the switch above the turn-off threshold) and a one-cycle millisecond tick. From these it produces a two-bit command that tells the analog switch driver which regime to run. It also produces a pulse that starts the converter's soft-start.

The controller has four regimes. In open, the switch does not conduct. In charge-limit, a closed loop holds the current at roughly 170 mA while the converter's input capacitor charges. In fully on, the switch is driven hard. In fault-limit, a closed loop holds the current at roughly 10.5 mA after an overload. A return from fault-limit to fully on requires two things: the capacitor must have recharged, and a programmable number of millisecond ticks (96 by default) must have passed since the fault began. The analog current loops, the comparators and the power device itself live outside this block.

Top module: `hsw_ctrl`

## Requirements
- R1: During and right after reset, `mode_o` is 2'b00 (open) and `dcdc_start_o` is 0.
- R2: From open, the block stays open while `uvlo_rel_i` is 0, whatever the comparator flags do. One cycle after `uvlo_rel_i` is seen high, `mode_o` becomes 2'b01 (charge-limit). Open never leads straight to any other mode.
- R3: In charge-limit, the over-threshold flag is ignored. The block stays in charge-limit until `vsw_low_i` is seen high, and `mode_o` reads 2'b10 (fully on) one cycle later.
- R4: `dcdc_start_o` is high for exactly one cycle: the first cycle of fully on that follows charge-limit. It stays low when fully on is re-entered from fault-limit.
- R5: In fully on, `vsw_high_i` moves the block to fault-limit, and `mode_o` reads 2'b11 one cycle later.
- R6: In fault-limit, `vsw_low_i` is ignored until `WAIT_MS` ticks of `ms_tick_i` have been counted in that fault-limit visit. With `WAIT_MS - 1` ticks counted, the block stays at 2'b11.
- R7: Once at least `WAIT_MS` ticks have been counted in fault-limit, a high `vsw_low_i` returns the block to fully on one cycle later. This holds however many extra ticks have arrived, because the dwell count saturates.
- R8: Whenever `uvlo_rel_i` is 0, the block is open in the next cycle, from any mode. This takes priority over both comparator flags.
- R9: Each new fault-limit visit starts its dwell count from zero. Ticks counted in an earlier visit do not shorten a later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uvlo_rel_i | input | 1 | 1 = input voltage above lockout, switch may operate |
| vsw_low_i | input | 1 | 1 = switch voltage below the turn-on threshold (capacitor recharged) |
| vsw_high_i | input | 1 | 1 = switch voltage above the turn-off threshold (overload) |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| mode_o | output | 2 | Switch regime: 00 open, 01 charge-limit, 10 fully on, 11 fault-limit |
| dcdc_start_o | output | 1 | One-cycle converter soft-start request |

## Verification
The bench counts the dwell ticks up to one short of the limit with the recharge flag already high. A counter that was off by one, or that compared with the wrong edge, would release the switch a tick early. It then goes past the limit to show that saturation keeps the release available, where a wrapping counter would trap the block in fault-limit. A second overload with only a few ticks checks that the count restarted, since a stale count would end that fault immediately. Lockout is dropped in every mode and raised together with the comparator flags, which catches a priority order that lets a comparator win over lockout. The re-entry to fully on from fault-limit confirms that no spurious soft-start pulse is issued there.

// File: rtl/hsw_pkg.sv
// Shared types for the hotswap pass-switch controller.
// Assumes the two-bit mode code is consumed directly by the analog driver.
package hsw_pkg;

    typedef enum logic [1:0] {
        SW_OPEN   = 2'b00,
        SW_CHARGE = 2'b01,
        SW_FULL   = 2'b10,
        SW_FAULT  = 2'b11
    } sw_mode_e;

endpackage

// File: rtl/hsw_dwell_timer.sv
// Saturating millisecond dwell counter.
// Counts tick pulses while enabled, clears to zero while disabled, and stops
// at LIMIT. Assumes tick is a single-cycle pulse in the clk domain.
module hsw_dwell_timer #(
    parameter int LIMIT = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count ticks while enabled, hold at the limit, clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q < LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Dwell satisfied once the count reaches the limit.
    always_comb done_o = (cnt_q >= LIM);

endmodule

// File: rtl/hsw_fsm.sv
// Four-regime sequencing machine for the pass switch.
// Lockout has priority over every comparator flag. Assumes the comparator
// flags are already synchronous to clk.
module hsw_fsm
    import hsw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     uvlo_rel_i,
    input  logic     vsw_low_i,
    input  logic     vsw_high_i,
    input  logic     dwell_done_i,
    output sw_mode_e state_o
);
    sw_mode_e state_q, state_d;

    // Next-regime decision.
    always_comb begin
        state_d = state_q;
        if (!uvlo_rel_i) begin
            state_d = SW_OPEN;
        end else begin
            case (state_q)
                SW_OPEN:   state_d = SW_CHARGE;
                SW_CHARGE: if (vsw_low_i) state_d = SW_FULL;
                SW_FULL:   if (vsw_high_i) state_d = SW_FAULT;
                SW_FAULT:  if (vsw_low_i && dwell_done_i) state_d = SW_FULL;
                default:   state_d = SW_OPEN;
            endcase
        end
    end

    // Regime register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_OPEN;
        else        state_q <= state_d;
    end

    always_comb state_o = state_q;

endmodule

// File: rtl/hsw_start_gen.sv
// Converter soft-start pulse generator.
// Flags the first cycle of fully on that directly follows charge-limit.
// Assumes the regime input is a registered signal.
module hsw_start_gen
    import hsw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sw_mode_e state_i,
    output logic     start_o
);
    sw_mode_e prev_q;

    // Remember last cycle's regime.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= SW_OPEN;
        else        prev_q <= state_i;
    end

    // Pulse only on the charge-limit to fully-on step.
    always_comb start_o = (prev_q == SW_CHARGE) && (state_i == SW_FULL);

endmodule

// File: rtl/hsw_ctrl.sv
// Hotswap pass-switch controller top.
// Ties the regime machine, the fault-limit dwell timer and the soft-start
// pulse generator together. Assumes all inputs are synchronous to clk.
module hsw_ctrl
    import hsw_pkg::*;
#(
    parameter int WAIT_MS = 96
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo_rel_i,
    input  logic       vsw_low_i,
    input  logic       vsw_high_i,
    input  logic       ms_tick_i,
    output logic [1:0] mode_o,
    output logic       dcdc_start_o
);
    sw_mode_e state;
    logic     dwell_done;
    logic     in_fault;

    // Timer runs only during a fault-limit visit.
    always_comb in_fault = (state == SW_FAULT);

    hsw_dwell_timer #(.LIMIT(WAIT_MS)) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (in_fault),
        .tick_i (ms_tick_i),
        .done_o (dwell_done)
    );

    hsw_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .uvlo_rel_i   (uvlo_rel_i),
        .vsw_low_i    (vsw_low_i),
        .vsw_high_i   (vsw_high_i),
        .dwell_done_i (dwell_done),
        .state_o      (state)
    );

    hsw_start_gen u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .start_o (dcdc_start_o)
    );

    // Drive the regime code straight to the analog driver.
    always_comb mode_o = state;

endmodule

// File: rtl/hsw_ctrl_chk.sv
// Property checker for hsw_ctrl, attached by bind.
// Keeps its own fault-limit tick count to judge the dwell window.
module hsw_ctrl_chk #(
    parameter int WAIT_MS = 96
) (
    input logic       clk,
    input logic       rst_n,
    input logic       uvlo_rel_i,
    input logic       vsw_low_i,
    input logic       vsw_high_i,
    input logic       ms_tick_i,
    input logic [1:0] mode_o,
    input logic       dcdc_start_o
);
    localparam int CW = $clog2(WAIT_MS + 1);
    localparam logic [CW-1:0] LIM = CW'(WAIT_MS);

    logic [CW-1:0] ticks_seen;

    // Independent count of ticks observed during the present fault visit.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ticks_seen <= '0;
        else if (mode_o != 2'b11)                ticks_seen <= '0;
        else if (ms_tick_i && ticks_seen < LIM)  ticks_seen <= ticks_seen + 1'b1;
    end

    AST_LOCKOUT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_rel_i |=> mode_o == 2'b00);                                  // R8
    AST_OPEN_TO_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && uvlo_rel_i) |=> mode_o == 2'b01);              // R2
    AST_CHARGE_TO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && uvlo_rel_i && vsw_low_i) |=> mode_o == 2'b10); // R3
    AST_FULL_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && uvlo_rel_i && vsw_high_i) |=> mode_o == 2'b11); // R5
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dcdc_start_o |=> !dcdc_start_o);                                   // R4
    AST_START_IN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        dcdc_start_o |-> mode_o == 2'b10);                                 // R4
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11 && ticks_seen < LIM) |=> mode_o != 2'b10);        // R6
    AST_RELEASE_AFTER_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11 && ticks_seen >= LIM && uvlo_rel_i && vsw_low_i)
        |=> mode_o == 2'b10);                                              // R7

endmodule

bind hsw_ctrl hsw_ctrl_chk #(.WAIT_MS(WAIT_MS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .uvlo_rel_i   (uvlo_rel_i),
    .vsw_low_i    (vsw_low_i),
    .vsw_high_i   (vsw_high_i),
    .ms_tick_i    (ms_tick_i),
    .mode_o       (mode_o),
    .dcdc_start_o (dcdc_start_o)
);

// File: tb/hsw_ctrl_test.sv
module hsw_ctrl_test;
    localparam int WAIT = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uvlo = 1'b0;
    logic       vlow = 1'b0;
    logic       vhigh = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] mode;
    logic       start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference model state.
    int m_state = 0;
    int m_cnt = 0;
    int m_prev = 0;

    always #2.5 clk = ~clk;

    hsw_ctrl #(.WAIT_MS(WAIT)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .uvlo_rel_i   (uvlo),
        .vsw_low_i    (vlow),
        .vsw_high_i   (vhigh),
        .ms_tick_i    (tick),
        .mode_o       (mode),
        .dcdc_start_o (start)
    );

    // Reference model: 0 open, 1 charge, 2 full, 3 fault.
    always @(posedge clk) begin
        int nxt;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_prev = 0;
        end else begin
            nxt = m_state;
            if (!uvlo) nxt = 0;
            else if (m_state == 0) nxt = 1;
            else if (m_state == 1 && vlow) nxt = 2;
            else if (m_state == 2 && vhigh) nxt = 3;
            else if (m_state == 3 && vlow && m_cnt >= WAIT) nxt = 2;
            if (m_state != 3) m_cnt = 0;
            else if (tick && m_cnt < WAIT) m_cnt = m_cnt + 1;
            m_prev = m_state;
            m_state = nxt;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(mode) != m_state) begin
                errors++;
                $display("FAIL %s model mode: actual %0d expected %0d",
                         (m_state == 3) ? "R6" : (m_state == 0) ? "R8" : "R3",
                         mode, m_state);
            end
            checks++;
            if (start != (m_prev == 1 && m_state == 2)) begin
                errors++;
                $display("FAIL R4 model start: actual %0b expected %0b",
                         start, (m_prev == 1 && m_state == 2));
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(1);
            tick = 1'b0; step(3);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        check("R1 reset mode", mode, 0);
        check("R1 reset start", start, 0);
        rst_n = 1'b1;
        step(1);
        check("R1 after reset", mode, 0);

        // R2: lockout holds open even with both flags high.
        vlow = 1'b1; vhigh = 1'b1;
        step(5);
        check("R2 held open", mode, 0);
        vlow = 1'b0;
        uvlo = 1'b1;
        step(1);
        check("R2 to charge", mode, 1);

        // R3: over-threshold ignored in charge-limit.
        step(4);
        check("R3 high ignored", mode, 1);
        vhigh = 1'b0; vlow = 1'b1;
        step(1);
        check("R3 to full", mode, 2);
        check("R4 start pulse", start, 1);
        vlow = 1'b0;
        step(1);
        check("R4 pulse ends", start, 0);

        // R5: overload.
        vhigh = 1'b1;
        step(1);
        check("R5 to fault", mode, 3);
        vhigh = 1'b0;

        // R6: one tick short of the dwell with recharge present.
        ticks(WAIT - 1);
        vlow = 1'b1;
        step(2);
        check("R6 early recharge ignored", mode, 3);
        vlow = 1'b0;

        // R7: reach and overrun the dwell, then recharge.
        ticks(1 + 20);
        check("R7 still fault", mode, 3);
        vlow = 1'b1;
        step(1);
        check("R7 back to full", mode, 2);
        check("R4 no start from fault", start, 0);
        vlow = 1'b0;

        // R9: second overload needs a fresh dwell.
        vhigh = 1'b1;
        step(1);
        vhigh = 1'b0;
        check("R9 fault again", mode, 3);
        ticks(10);
        vlow = 1'b1;
        step(2);
        check("R9 fresh dwell", mode, 3);

        // R8: lockout from fault with recharge high.
        uvlo = 1'b0;
        step(1);
        check("R8 fault to open", mode, 0);
        vlow = 1'b0;

        // R8: lockout from charge, racing recharge.
        uvlo = 1'b1;
        step(1);
        check("R2 charge again", mode, 1);
        uvlo = 1'b0; vlow = 1'b1;
        step(1);
        check("R8 priority over recharge", mode, 0);
        check("R8 no start", start, 0);

        // R8: lockout from full.
        uvlo = 1'b1;
        step(2);
        check("R3 full again", mode, 2);
        vlow = 1'b0;
        uvlo = 1'b0; vhigh = 1'b1;
        step(1);
        check("R8 full to open", mode, 0);
        vhigh = 1'b0;
        step(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule